// File: doc/BRIEF.md
# Multidrop UART Frame Receiver

This block receives asynchronous serial frames on a shared, multi-controller line. It oversamples the incoming line with a sample-clock enable that pulses `OSR` times per bit period. It finds and confirms the start bit, then samples the data bits least-significant first. When the configuration asks for it, it also captures a ninth bit that sits between the data and the stop bit. It ends by sampling the stop bit.

In multidrop mode the ninth bit is a wake-up marker. A wake-up bit of 1 marks an address (ID) frame and a wake-up bit of 0 marks a data frame. A receive-wake control picks which of the two kinds the receiver accepts. Frames of the other kind are dropped without leaving any trace at the outputs.

Outside multidrop mode the ninth bit is present only when parity checking is enabled, and it then carries odd or even parity. Every accepted frame produces a one-cycle valid strobe, together with the byte and the parity and framing error flags.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After a synchronous reset, `rx_valid`, `frm_err` and `par_err` are 0 and `rx_data` is 0.
- R2: Each bit spans `OSR` pulses of `samp_en`. The 8 data bits follow the start bit least-significant first. An accepted frame drives `rx_valid` high for exactly one clock with the received byte on `rx_data`.
- R3: A start is recognised only on a high-to-low change of the sampled line. If the line is high again at the mid-bit sample (`OSR/2` samples later), the low is noise: no frame is produced and reception returns to idle.
- R4: `mode` values 2'b10 and 2'b11 select multidrop operation. In multidrop operation one wake-up bit follows the data bits, before the stop bit.
- R5: In multidrop operation with `wake_sel` = 0, only frames whose wake-up bit is 0 are accepted.
- R6: In multidrop operation with `wake_sel` = 1, only frames whose wake-up bit is 1 are accepted. A rejected frame gives no `rx_valid`, no `frm_err` and no `par_err`, even when its stop bit is low.
- R7: With `mode` 2'b00 or 2'b01 and `par_en` = 0, a frame has no ninth bit and `wake_sel` has no effect on acceptance.
- R8: Outside multidrop operation with `par_en` = 1, a parity bit follows the data. With `par_even` = 1 the data plus the parity bit hold an even number of ones; with `par_even` = 0 they hold an odd number. A mismatch raises `par_err` in the same cycle as `rx_valid`.
- R9: In multidrop operation `par_en` is ignored. The only ninth bit is the wake-up bit, and `par_err` stays 0.
- R10: A stop bit sampled low raises `frm_err` in the same cycle as `rx_valid`, and the byte is still presented. A new start then needs the line to return high first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Oversampling enable, `OSR` pulses per bit |
| rxd | input | 1 | Serial receive line, idle high |
| mode | input | 2 | Line mode; 2'b1x selects multidrop operation |
| wake_sel | input | 1 | Multidrop filter: 0 accepts data frames, 1 accepts address frames |
| par_en | input | 1 | Parity check enable (non-multidrop only) |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| rx_data | output | 8 | Last accepted byte |
| rx_valid | output | 1 | One-cycle strobe for an accepted frame |
| par_err | output | 1 | Parity mismatch, qualified by `rx_valid` |
| frm_err | output | 1 | Stop bit low, qualified by `rx_valid` |

## Verification
The bench builds the receiver with `OSR` = 8 and pulses `samp_en` on every other clock, so one bit lasts 16 clocks. At this setting the noise window is four samples wide, and a two-sample glitch falls inside it, so the start-rejection path can be reached with short stimulus.

The halved enable rate also checks that the counters advance only on enabled samples. The reduced bit length lets every mode, wake-up filter setting, parity sense and framing error case fit into a short run. Throughout the run, a reference model that keeps a queue of expected bytes is checked against the outputs on every clock.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_NINTH = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdrop_rx_shift.sv
module mdrop_rx_shift
  import mdrop_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_en,
  input  logic              rxs,
  input  logic              ninth_en,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              ninth,
  output logic              stop_bit
);
  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int IW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID_C  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL_C = CW'(OSR - 1);
  localparam logic [IW-1:0] LAST_C = IW'(DATA_W - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic              prev;
  logic              ninth_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      prev     <= 1'b1;
      ninth_q  <= 1'b0;
      word     <= '0;
      ninth    <= 1'b0;
      stop_bit <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (samp_en) begin
        prev <= rxs;
        case (st)
          ST_IDLE: begin
            if (prev && !rxs) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID_C) begin
              cnt <= '0;
              if (rxs) begin
                st <= ST_IDLE;
              end else begin
                st      <= ST_DATA;
                idx     <= '0;
                ninth_q <= ninth_en;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == FULL_C) begin
              cnt  <= '0;
              word <= {rxs, word[DATA_W-1:1]};
              if (idx == LAST_C) st <= ninth_q ? ST_NINTH : ST_STOP;
              else               idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_NINTH: begin
            if (cnt == FULL_C) begin
              cnt   <= '0;
              ninth <= rxs;
              st    <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == FULL_C) begin
              cnt      <= '0;
              stop_bit <= rxs;
              done     <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdrop_rx_judge.sv
module mdrop_rx_judge #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  logic              ninth,
  input  logic              stop_bit,
  input  logic              multidrop,
  input  logic              wake_sel,
  input  logic              par_en,
  input  logic              par_even,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err
);
  logic accept, check_par, want_par;

  always_comb begin
    accept    = !multidrop || (ninth == wake_sel);
    check_par = par_en && !multidrop;
    want_par  = par_even ? (^word) : ~(^word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      rx_valid <= done && accept;
      frm_err  <= done && accept && !stop_bit;
      par_err  <= done && accept && check_par && (ninth != want_par);
      if (done && accept) rx_data <= word;
    end
  end
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx #(
  parameter int OSR       = 16,
  parameter int DATA_W    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_en,
  input  logic              rxd,
  input  logic [1:0]        mode,
  input  logic              wake_sel,
  input  logic              par_en,
  input  logic              par_even,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err
);
  logic              rxs;
  logic              multidrop;
  logic              done;
  logic [DATA_W-1:0] word;
  logic              ninth;
  logic              stop_bit;

  assign multidrop = mode[1];

  mdrop_rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk), .rst (rst), .din (rxd), .dout (rxs)
  );

  mdrop_rx_shift #(.OSR(OSR), .DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (samp_en),
    .rxs      (rxs),
    .ninth_en (multidrop || par_en),
    .done     (done),
    .word     (word),
    .ninth    (ninth),
    .stop_bit (stop_bit)
  );

  mdrop_rx_judge #(.DATA_W(DATA_W)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .word      (word),
    .ninth     (ninth),
    .stop_bit  (stop_bit),
    .multidrop (multidrop),
    .wake_sel  (wake_sel),
    .par_en    (par_en),
    .par_even  (par_even),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .par_err   (par_err),
    .frm_err   (frm_err)
  );
endmodule

// File: rtl/mdrop_uart_rx_chk.sv
module mdrop_uart_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       rx_valid,
  input logic       par_err,
  input logic       frm_err
);
  // R1: outputs quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rx_valid && !par_err && !frm_err));

  // R2: valid is a single-cycle strobe
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R10: framing error only alongside a presented byte
  p_frm_with_valid_r10: assert property (@(posedge clk) disable iff (rst)
    frm_err |-> rx_valid);

  // R8: parity error only alongside a presented byte
  p_par_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    par_err |-> rx_valid);

  // R9: no parity error when the line was in multidrop mode
  p_no_par_multidrop_r9: assert property (@(posedge clk) disable iff (rst)
    par_err |-> !$past(mode[1]));
endmodule

bind mdrop_uart_rx mdrop_uart_rx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .rx_valid (rx_valid),
  .par_err  (par_err),
  .frm_err  (frm_err)
);

// File: tb/mdrop_uart_rx_test.sv
module mdrop_uart_rx_test;
  localparam int OSR = 8;
  localparam int BIT_CLKS = 2 * OSR;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       samp_en;
  logic       rxd = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       wake_sel = 1'b0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err;

  int checks = 0;
  int errors = 0;

  logic [7:0] q_data[$];
  logic       q_frm[$];
  logic       q_par[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) samp_en <= 1'b0;
    else     samp_en <= ~samp_en;
  end

  mdrop_uart_rx #(.OSR(OSR)) uut (
    .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd),
    .mode(mode), .wake_sel(wake_sel), .par_en(par_en), .par_even(par_even),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference: every clock, compare strobes against the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (q_data.size() == 0) begin
          check(0, "R6", "unexpected rx_valid", 1, 0);
        end else begin
          automatic logic [7:0] d = q_data.pop_front();
          automatic logic f = q_frm.pop_front();
          automatic logic p = q_par.pop_front();
          automatic string t = q_tag.pop_front();
          check(rx_data == d, t, "rx_data", rx_data, d);
          check(frm_err == f, t, "frm_err", frm_err, f);
          check(par_err == p, t, "par_err", par_err, p);
        end
      end else if (frm_err || par_err) begin
        check(0, "R10", "error flag without valid", {frm_err, par_err}, 0);
      end
    end
  end

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // ninth_kind: 0 none, 1 given bit
  task automatic frame(input logic [7:0] d, input bit has9, input logic b9,
                       input logic stopv, input bit expect_ok,
                       input logic exp_frm, input logic exp_par, input string tag);
    if (expect_ok) begin
      q_data.push_back(d); q_frm.push_back(exp_frm);
      q_par.push_back(exp_par); q_tag.push_back(tag);
    end
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (has9) send_bit(b9);
    send_bit(stopv);
    send_bit(1'b1);
    send_bit(1'b1);
    check(q_data.size() == 0, tag, "pending frames after idle", q_data.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rx_valid && !frm_err && !par_err && rx_data == 8'h00, "R1",
          "reset outputs", {rx_valid, frm_err, par_err, rx_data}, 0);
    send_bit(1'b1);

    // R2 / R7: plain frames, wake_sel irrelevant
    frame(8'hA5, 0, 1'b0, 1'b1, 1, 0, 0, "R2");
    frame(8'h00, 0, 1'b0, 1'b1, 1, 0, 0, "R2");
    wake_sel = 1'b1;
    frame(8'h3C, 0, 1'b0, 1'b1, 1, 0, 0, "R7");
    mode = 2'b01;
    frame(8'hFF, 0, 1'b0, 1'b1, 1, 0, 0, "R7");
    wake_sel = 1'b0;

    // R3: short low glitch, then a good frame
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    send_bit(1'b1);
    send_bit(1'b1);
    check(q_data.size() == 0 && !rx_valid, "R3", "glitch produced output", rx_valid, 0);
    frame(8'h5A, 0, 1'b0, 1'b1, 1, 0, 0, "R3");

    // R4 / R5: multidrop, accept data frames
    mode = 2'b10; wake_sel = 1'b0;
    frame(8'h11, 1, 1'b0, 1'b1, 1, 0, 0, "R5");
    frame(8'h22, 1, 1'b1, 1'b1, 0, 0, 0, "R5");
    frame(8'h96, 1, 1'b0, 1'b1, 1, 0, 0, "R4");

    // R6: multidrop, accept address frames; rejected one with bad stop
    mode = 2'b11; wake_sel = 1'b1;
    frame(8'h33, 1, 1'b1, 1'b1, 1, 0, 0, "R6");
    frame(8'h44, 1, 1'b0, 1'b0, 0, 0, 0, "R6");
    frame(8'hC3, 1, 1'b1, 1'b1, 1, 0, 0, "R6");

    // R9: parity enable ignored in multidrop
    mode = 2'b10; wake_sel = 1'b0; par_en = 1'b1; par_even = 1'b1;
    frame(8'h01, 1, 1'b0, 1'b1, 1, 0, 0, "R9");

    // R8: parity outside multidrop
    mode = 2'b00; par_even = 1'b1;
    frame(8'h0F, 1, 1'b0, 1'b1, 1, 0, 0, "R8");
    frame(8'h0F, 1, 1'b1, 1'b1, 1, 0, 1, "R8");
    frame(8'h07, 1, 1'b1, 1'b1, 1, 0, 0, "R8");
    par_even = 1'b0;
    frame(8'h07, 1, 1'b0, 1'b1, 1, 0, 0, "R8");
    frame(8'h07, 1, 1'b1, 1'b1, 1, 0, 1, "R8");
    par_en = 1'b0;

    // R10: stop bit low, then recovery
    frame(8'h81, 0, 1'b0, 1'b0, 1, 1, 0, "R10");
    frame(8'h7E, 0, 1'b0, 1'b1, 1, 0, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule